// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

The block is a processor core that completes one RV32I-subset instruction in every clock cycle. Instruction and data storage sit outside it. The core presents the program counter, and it receives the instruction word addressed by that counter in the same cycle. It also presents a data address, write data and a write strobe, and it receives load data combinationally.

Inside the core, a decoder examines the whole instruction word. It issues a next-PC selection code, the operand-B source, the ALU operation, the write-back source, the store strobe and the register write enable. It also extends the I, S or B immediate to a signed value.

The ALU result drives the data address and feeds the write-back path. The ALU's zero, negative, carry and overflow flags go to a separate next-PC stage. That stage resolves the branch and either adds 4 or adds the branch offset. Integrators use the core in a single-cycle system with asynchronous-read memories. Unsupported encodings retire as no-operations.

Top module: `rv_core_sc`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, the PC becomes 0 and every register x1..x31 becomes 0. Reset is synchronous, so the PC keeps its value until that edge.
- R2: R-type instructions (opcode 0110011) compute rs1 op rs2 and write the result to rd. The operations are ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR and AND, selected by funct3 plus instruction bit 30. The ALU result always appears on `dmem_addr_o`.
- R3: I-type arithmetic (opcode 0010011) uses the sign-extended 12-bit immediate in bits 31:20 as operand B. It covers ADDI, SLTI, SLTIU, XORI, ORI and ANDI, plus SLLI, SRLI and SRAI, where bit 30 selects the arithmetic shift.
- R4: LW (opcode 0000011, funct3 010) drives `dmem_addr_o` = rs1 + immediate, keeps `dmem_we_o` low, and writes `dmem_rdata_i` to rd.
- R5: SW (opcode 0100011, funct3 010) drives `dmem_addr_o` = rs1 + S-immediate, drives `dmem_wdata_o` = rs2, and raises `dmem_we_o`. It writes no register. `dmem_we_o` is high for no other instruction.
- R6: Register x0 reads as zero, and writes that address it are dropped.
- R7: BEQ and BNE (opcode 1100011, funct3 000 and 001) compute rs1 - rs2. The next PC is PC + B-immediate when the branch is taken and PC + 4 otherwise. The B-immediate has an implicit zero bit 0 and may be negative. A branch writes no register.
- R8: BLT and BGE (funct3 100 and 101) compare signed values, and they are correct when the subtraction overflows. BLTU and BGEU (funct3 110 and 111) compare unsigned values.
- R9: An unsupported encoding writes no register, leaves `dmem_we_o` low and advances the PC by 4. This covers other opcodes, loads and stores whose funct3 is not 010, and branches with funct3 010 or 011.
- R10: Every instruction other than a taken branch advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_o | output | 32 | Current program counter, to instruction storage |
| instr_i | input | 32 | Instruction word at `pc_o` |
| dmem_addr_o | output | 32 | ALU result, used as data address |
| dmem_wdata_o | output | 32 | Store data (rs2 value) |
| dmem_we_o | output | 1 | Data write strobe, high only for SW |
| dmem_rdata_i | input | 32 | Load data for the current address |

## Verification
The bench builds the core with its default 32-bit data width and a 5-bit register index. At these values, signed overflow at 0x80000000 and shifts by 31 and 28 are both within reach. Register state is made visible through stores, and sign extension is checked across the full word. Next-PC behaviour is checked as the PC step after each edge, including negative branch offsets and branches that do not resolve the same way as their signed or unsigned counterparts.

// File: rtl/rvc_pkg.sv
// Shared types for the single-cycle core: opcodes, ALU operations,
// next-PC selection codes, ALU status flags and the decoded control word.
package rvc_pkg;

    localparam logic [6:0] OP_REG  = 7'b0110011;
    localparam logic [6:0] OP_IMM  = 7'b0010011;
    localparam logic [6:0] OP_LOAD = 7'b0000011;
    localparam logic [6:0] OP_STOR = 7'b0100011;
    localparam logic [6:0] OP_BRCH = 7'b1100011;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_SLTU
    } alu_op_t;

    typedef enum logic [2:0] {
        NXT_SEQ, NXT_EQ, NXT_NE, NXT_LT, NXT_GE, NXT_LTU, NXT_GEU
    } nxt_sel_t;

    typedef enum logic [1:0] {
        IMM_I, IMM_S, IMM_B
    } imm_fmt_t;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;

    typedef struct packed {
        nxt_sel_t nxt;
        logic     wb_from_mem;
        logic     store_en;
        alu_op_t  alu_op;
        logic     opb_is_imm;
        logic     reg_wen;
    } ctrl_t;

endpackage

// File: rtl/rvc_decode.sv
// Instruction decoder and immediate extender.
// Takes the whole 32-bit word and yields the control word, register indices
// and the sign-extended immediate. Assumes the instruction is valid for the
// whole cycle; unsupported encodings decode to a no-operation.
module rvc_decode
    import rvc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    output ctrl_t           ctrl,
    output logic [4:0]      rs1_idx,
    output logic [4:0]      rs2_idx,
    output logic [4:0]      rd_idx,
    output logic [XLEN-1:0] imm
);

    logic [6:0] opcode;
    logic [2:0] funct3;
    logic       alt_bit;
    imm_fmt_t   imm_fmt;

    assign opcode  = instr[6:0];
    assign funct3  = instr[14:12];
    assign alt_bit = instr[30];
    assign rs1_idx = instr[19:15];
    assign rs2_idx = instr[24:20];
    assign rd_idx  = instr[11:7];

    // Map funct3 plus the alternate bit to an ALU operation.
    function automatic alu_op_t arith_op(input logic [2:0] f3, input logic alt);
        case (f3)
            3'b000:  arith_op = alt ? ALU_SUB : ALU_ADD;
            3'b001:  arith_op = ALU_SLL;
            3'b010:  arith_op = ALU_SLT;
            3'b011:  arith_op = ALU_SLTU;
            3'b100:  arith_op = ALU_XOR;
            3'b101:  arith_op = alt ? ALU_SRA : ALU_SRL;
            3'b110:  arith_op = ALU_OR;
            default: arith_op = ALU_AND;
        endcase
    endfunction

    // Produce control signals from opcode and function fields.
    always_comb begin
        ctrl.nxt         = NXT_SEQ;
        ctrl.wb_from_mem = 1'b0;
        ctrl.store_en    = 1'b0;
        ctrl.alu_op      = ALU_ADD;
        ctrl.opb_is_imm  = 1'b1;
        ctrl.reg_wen     = 1'b0;
        imm_fmt          = IMM_I;
        case (opcode)
            OP_REG: begin
                ctrl.reg_wen    = 1'b1;
                ctrl.opb_is_imm = 1'b0;
                ctrl.alu_op     = arith_op(funct3, alt_bit);
            end
            OP_IMM: begin
                ctrl.reg_wen = 1'b1;
                ctrl.alu_op  = arith_op(funct3, alt_bit && (funct3 == 3'b101));
            end
            OP_LOAD: begin
                if (funct3 == 3'b010) begin
                    ctrl.reg_wen     = 1'b1;
                    ctrl.wb_from_mem = 1'b1;
                end
            end
            OP_STOR: begin
                imm_fmt = IMM_S;
                if (funct3 == 3'b010) ctrl.store_en = 1'b1;
            end
            OP_BRCH: begin
                imm_fmt         = IMM_B;
                ctrl.alu_op     = ALU_SUB;
                ctrl.opb_is_imm = 1'b0;
                case (funct3)
                    3'b000:  ctrl.nxt = NXT_EQ;
                    3'b001:  ctrl.nxt = NXT_NE;
                    3'b100:  ctrl.nxt = NXT_LT;
                    3'b101:  ctrl.nxt = NXT_GE;
                    3'b110:  ctrl.nxt = NXT_LTU;
                    3'b111:  ctrl.nxt = NXT_GEU;
                    default: ctrl.nxt = NXT_SEQ;
                endcase
            end
            default: ;
        endcase
    end

    // Assemble and sign-extend the immediate for the selected format.
    always_comb begin
        case (imm_fmt)
            IMM_S:   imm = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
            IMM_B:   imm = {{(XLEN-12){instr[31]}}, instr[7], instr[30:25],
                            instr[11:8], 1'b0};
            default: imm = {{(XLEN-12){instr[31]}}, instr[31:20]};
        endcase
    end

endmodule

// File: rtl/rvc_alu.sv
// Integer ALU with zero/negative/carry/overflow flags.
// One shared adder serves add, subtract and both compares; carry is the
// adder carry-out (set means no borrow on subtract).
module rvc_alu
    import rvc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_t         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output alu_flags_t      flags
);

    localparam int SHW = $clog2(XLEN);

    logic            use_sub;
    logic [XLEN-1:0] b_eff;
    logic [XLEN:0]   sum;
    logic            ovf;
    logic [SHW-1:0]  shamt;

    assign use_sub = (op == ALU_SUB) || (op == ALU_SLT) || (op == ALU_SLTU);
    assign b_eff   = use_sub ? ~b : b;
    assign sum     = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, use_sub};
    assign ovf     = (a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != a[XLEN-1]);
    assign shamt   = b[SHW-1:0];

    // Select the result for the requested operation.
    always_comb begin
        case (op)
            ALU_ADD, ALU_SUB: y = sum[XLEN-1:0];
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_SLL:  y = a << shamt;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = $unsigned($signed(a) >>> shamt);
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, sum[XLEN-1] ^ ovf};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, ~sum[XLEN]};
            default:  y = '0;
        endcase
    end

    // Report status from the result and the shared adder.
    always_comb begin
        flags.z = (y == '0);
        flags.n = y[XLEN-1];
        flags.c = sum[XLEN];
        flags.v = ovf;
    end

endmodule

// File: rtl/rvc_regfile.sv
// Register file: two combinational read ports, one write port on the
// rising edge. Entry 0 is not stored and always reads zero. All stored
// entries clear on synchronous active-low reset.
module rvc_regfile #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    localparam int NREGS = 1 << AW;

    logic [XLEN-1:0] regs [NREGS];

    assign regs[0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        // Hold one register; load it when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && (wa == AW'(g)))
                regs[g] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

endmodule

// File: rtl/rvc_pc.sv
// Next-PC logic and program counter register. Resolves the branch from the
// selection code and ALU flags, then adds 4 or the branch offset.
// Assumes the flags come from rs1 - rs2 whenever the code is not sequential.
module rvc_pc
    import rvc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  nxt_sel_t        nxt,
    input  alu_flags_t      flags,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] pc
);

    logic            taken;
    logic [XLEN-1:0] pc_next;

    // Decide whether the branch condition holds.
    always_comb begin
        case (nxt)
            NXT_EQ:  taken = flags.z;
            NXT_NE:  taken = ~flags.z;
            NXT_LT:  taken = flags.n ^ flags.v;
            NXT_GE:  taken = ~(flags.n ^ flags.v);
            NXT_LTU: taken = ~flags.c;
            NXT_GEU: taken = flags.c;
            default: taken = 1'b0;
        endcase
    end

    assign pc_next = pc + (taken ? offset : XLEN'(4));

    // Advance the counter, or clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else
            pc <= pc_next;
    end

endmodule

// File: rtl/rv_core_sc.sv
// Single-cycle RV32I-subset core top. Wires decoder, register file, ALU and
// next-PC stage. Assumes asynchronous-read instruction and data storage.
module rv_core_sc
    import rvc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] pc_o,
    input  logic [31:0]     instr_i,
    output logic [XLEN-1:0] dmem_addr_o,
    output logic [XLEN-1:0] dmem_wdata_o,
    output logic            dmem_we_o,
    input  logic [XLEN-1:0] dmem_rdata_i
);

    ctrl_t           ctrl;
    alu_flags_t      flags;
    logic [4:0]      rs1_idx;
    logic [4:0]      rs2_idx;
    logic [4:0]      rd_idx;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rs2_val;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] wb_val;
    logic            rf_we;

    rvc_decode #(.XLEN(XLEN)) u_dec (
        .instr   (instr_i),
        .ctrl    (ctrl),
        .rs1_idx (rs1_idx),
        .rs2_idx (rs2_idx),
        .rd_idx  (rd_idx),
        .imm     (imm)
    );

    rvc_regfile #(.XLEN(XLEN), .AW(AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (AW'(rs1_idx)),
        .ra2   (AW'(rs2_idx)),
        .rd1   (rs1_val),
        .rd2   (rs2_val),
        .we    (rf_we),
        .wa    (AW'(rd_idx)),
        .wd    (wb_val)
    );

    assign opb = ctrl.opb_is_imm ? imm : rs2_val;

    rvc_alu #(.XLEN(XLEN)) u_alu (
        .op    (ctrl.alu_op),
        .a     (rs1_val),
        .b     (opb),
        .y     (alu_y),
        .flags (flags)
    );

    rvc_pc #(.XLEN(XLEN)) u_pc (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt    (ctrl.nxt),
        .flags  (flags),
        .offset (imm),
        .pc     (pc_o)
    );

    assign rf_we        = ctrl.reg_wen;
    assign wb_val       = ctrl.wb_from_mem ? dmem_rdata_i : alu_y;
    assign dmem_addr_o  = alu_y;
    assign dmem_wdata_o = rs2_val;
    assign dmem_we_o    = ctrl.store_en;

endmodule

// File: rtl/rv_core_sc_chk.sv
// Property checker for rv_core_sc, attached by bind. Observes the opcode,
// PC, store strobe and the internal register write enable.
module rv_core_sc_chk
    import rvc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [6:0]      opcode,
    input logic [XLEN-1:0] pc_o,
    input logic            dmem_we_o,
    input logic            rf_we
);

    logic rst_seen_q = 1'b0;

    // Remember whether the last edge sampled reset low.
    always_ff @(posedge clk) rst_seen_q <= ~rst_n;

    // R1: after a reset edge the PC is zero.
    always @(negedge clk) begin
        if (rst_seen_q) begin
            a_reset_pc_r1: assert (pc_o == '0);
        end
    end

    // R5: store strobe only for the store opcode.
    p_store_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we_o |-> (opcode == OP_STOR));

    // R7: branches never write a register.
    p_branch_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_BRCH) |-> !rf_we);

    // R9: unknown opcodes write neither registers nor memory.
    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OP_REG && opcode != OP_IMM && opcode != OP_LOAD &&
         opcode != OP_STOR && opcode != OP_BRCH) |-> (!rf_we && !dmem_we_o));

    // R10: non-branch instructions step the PC by 4.
    p_seq_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != OP_BRCH) |=> (pc_o == $past(pc_o) + XLEN'(4)));

endmodule

bind rv_core_sc rv_core_sc_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opcode    (instr_i[6:0]),
    .pc_o      (pc_o),
    .dmem_we_o (dmem_we_o),
    .rf_we     (rf_we)
);

// File: tb/rv_core_sc_test.sv
module rv_core_sc_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc_o;
    logic [31:0] instr_i;
    logic [31:0] dmem_addr_o;
    logic [31:0] dmem_wdata_o;
    logic        dmem_we_o;
    logic [31:0] dmem_rdata_i;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rv_core_sc uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pc_o         (pc_o),
        .instr_i      (instr_i),
        .dmem_addr_o  (dmem_addr_o),
        .dmem_wdata_o (dmem_wdata_o),
        .dmem_we_o    (dmem_we_o),
        .dmem_rdata_i (dmem_rdata_i)
    );

    typedef struct packed {
        logic [31:0] ins;
        logic [31:0] rdat;
        logic        chka;
        logic [31:0] addr;
        logic        we;
        logic [31:0] wd;
        logic [31:0] step;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2,
                                          logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] rs1,
                                          logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
        return {im, rs1, f3, rd, op};
    endfunction

    function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] rs2, logic [4:0] rs1);
        return {im[11:5], rs2, rs1, 3'b010, im[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] rs2,
                                          logic [4:0] rs1, logic [2:0] f3);
        return {im[12], im[10:5], rs2, rs1, f3, im[4:1], im[11], 7'b1100011};
    endfunction

    function automatic vec_t mk(logic [31:0] ins, logic [31:0] rdat, logic chka,
                                logic [31:0] addr, logic we, logic [31:0] wd,
                                logic [31:0] step, logic [7:0] req);
        return '{ins: ins, rdat: rdat, chka: chka, addr: addr, we: we, wd: wd,
                 step: step, req: req};
    endfunction

    localparam logic [6:0] OI = 7'b0010011;
    localparam logic [6:0] OL = 7'b0000011;
    localparam int NV = 50;

    localparam vec_t VECS [NV] = '{
        mk(enc_i(12'd5, 0, 3'b000, 1, OI), 0, 1, 32'd5, 0, 0, 4, 3),            // R3 addi x1=5
        mk(enc_i(12'hFFD, 0, 3'b000, 2, OI), 0, 1, 32'hFFFFFFFD, 0, 0, 4, 3),   // R3 addi x2=-3
        mk(enc_r(0, 2, 1, 3'b000, 3), 0, 1, 32'd2, 0, 0, 4, 2),                 // R2 add
        mk(enc_r(7'h20, 1, 2, 3'b000, 4), 0, 1, 32'hFFFFFFF8, 0, 0, 4, 2),      // R2 sub
        mk(enc_s(12'd8, 4, 1), 0, 1, 32'd13, 1, 32'hFFFFFFF8, 4, 5),            // R5 sw
        mk(enc_s(12'd0, 8, 0), 0, 1, 32'd0, 1, 32'd0, 4, 5),                    // R5 x8 untouched
        mk(enc_i(12'd4, 0, 3'b010, 5, OL), 32'h12345678, 1, 32'd4, 0, 0, 4, 4), // R4 lw
        mk(enc_s(12'd0, 5, 3), 0, 1, 32'd2, 1, 32'h12345678, 4, 4),             // R4 loaded value
        mk(enc_i(12'd7, 0, 3'b000, 0, OI), 0, 1, 32'd7, 0, 0, 4, 6),            // R6 write x0
        mk(enc_s(12'd0, 0, 1), 0, 1, 32'd5, 1, 32'd0, 4, 6),                    // R6 x0 reads 0
        mk(enc_r(0, 1, 0, 3'b000, 6), 0, 1, 32'd5, 0, 0, 4, 6),                 // R6 x0 operand
        mk(enc_r(0, 1, 2, 3'b010, 6), 0, 1, 32'd1, 0, 0, 4, 2),                 // R2 slt
        mk(enc_r(0, 1, 2, 3'b011, 7), 0, 1, 32'd0, 0, 0, 4, 2),                 // R2 sltu
        mk(enc_r(0, 2, 1, 3'b111, 8), 0, 1, 32'd5, 0, 0, 4, 2),                 // R2 and
        mk(enc_r(0, 2, 1, 3'b110, 8), 0, 1, 32'hFFFFFFFD, 0, 0, 4, 2),          // R2 or
        mk(enc_r(0, 2, 1, 3'b100, 8), 0, 1, 32'hFFFFFFF8, 0, 0, 4, 2),          // R2 xor
        mk(enc_r(0, 1, 1, 3'b001, 9), 0, 1, 32'h000000A0, 0, 0, 4, 2),          // R2 sll
        mk(enc_r(0, 1, 2, 3'b101, 9), 0, 1, 32'h07FFFFFF, 0, 0, 4, 2),          // R2 srl
        mk(enc_r(7'h20, 1, 2, 3'b101, 9), 0, 1, 32'hFFFFFFFF, 0, 0, 4, 2),      // R2 sra
        mk(enc_i(12'h401, 2, 3'b101, 10, OI), 0, 1, 32'hFFFFFFFE, 0, 0, 4, 3),  // R3 srai
        mk(enc_i(12'd28, 2, 3'b101, 11, OI), 0, 1, 32'h0000000F, 0, 0, 4, 3),   // R3 srli
        mk(enc_i(12'd1, 0, 3'b000, 12, OI), 0, 1, 32'd1, 0, 0, 4, 3),           // R3 addi
        mk(enc_i(12'd31, 12, 3'b001, 12, OI), 0, 1, 32'h80000000, 0, 0, 4, 3),  // R3 slli 31
        mk(enc_i(12'hFFF, 1, 3'b100, 13, OI), 0, 1, 32'hFFFFFFFA, 0, 0, 4, 3),  // R3 xori
        mk(enc_i(12'h00F, 2, 3'b111, 13, OI), 0, 1, 32'h0000000D, 0, 0, 4, 3),  // R3 andi
        mk(enc_i(12'h7FF, 0, 3'b110, 13, OI), 0, 1, 32'h000007FF, 0, 0, 4, 3),  // R3 ori
        mk(enc_i(12'hFFE, 2, 3'b010, 13, OI), 0, 1, 32'd1, 0, 0, 4, 3),         // R3 slti
        mk(enc_i(12'hFFF, 1, 3'b011, 13, OI), 0, 1, 32'd1, 0, 0, 4, 3),         // R3 sltiu
        mk(enc_i(12'd1, 0, 3'b000, 13, OI), 0, 1, 32'd1, 0, 0, 4, 3),           // R3 x13=1
        mk(enc_b(13'd16, 1, 1, 3'b000), 0, 1, 32'd0, 0, 0, 16, 7),              // R7 beq taken
        mk(enc_s(12'd0, 16, 0), 0, 1, 32'd0, 1, 32'd0, 4, 7),                   // R7 x16 untouched
        mk(enc_b(13'd16, 2, 1, 3'b000), 0, 1, 32'd8, 0, 0, 4, 7),               // R7 beq not
        mk(enc_b(13'd8, 1, 1, 3'b001), 0, 1, 32'd0, 0, 0, 4, 7),                // R7 bne not
        mk(enc_b(13'h1FF8, 2, 1, 3'b001), 0, 1, 32'd8, 0, 0, 32'hFFFFFFF8, 7),  // R7 bne back
        mk(enc_b(13'd12, 1, 2, 3'b100), 0, 1, 32'hFFFFFFF8, 0, 0, 12, 8),       // R8 blt taken
        mk(enc_b(13'd12, 2, 1, 3'b100), 0, 1, 32'd8, 0, 0, 4, 8),               // R8 blt not
        mk(enc_b(13'd20, 2, 1, 3'b101), 0, 1, 32'd8, 0, 0, 20, 8),              // R8 bge taken
        mk(enc_b(13'd20, 1, 2, 3'b101), 0, 1, 32'hFFFFFFF8, 0, 0, 4, 8),        // R8 bge not
        mk(enc_b(13'd20, 1, 1, 3'b101), 0, 1, 32'd0, 0, 0, 20, 8),              // R8 bge equal
        mk(enc_b(13'd24, 13, 12, 3'b100), 0, 1, 32'h7FFFFFFF, 0, 0, 24, 8),     // R8 blt overflow
        mk(enc_b(13'd28, 12, 13, 3'b101), 0, 1, 32'h80000001, 0, 0, 28, 8),     // R8 bge overflow
        mk(enc_b(13'd12, 1, 2, 3'b110), 0, 1, 32'hFFFFFFF8, 0, 0, 4, 8),        // R8 bltu not
        mk(enc_b(13'd12, 1, 2, 3'b111), 0, 1, 32'hFFFFFFF8, 0, 0, 12, 8),       // R8 bgeu taken
        mk(enc_b(13'd16, 2, 1, 3'b110), 0, 1, 32'd8, 0, 0, 16, 8),              // R8 bltu taken
        mk(32'h000000EF, 0, 0, 0, 0, 0, 4, 9),                                  // R9 jump-like
        mk(32'h000050B7, 0, 0, 0, 0, 0, 4, 9),                                  // R9 upper-imm
        mk(32'h00000083, 32'hDEADBEEF, 0, 0, 0, 0, 4, 9),                       // R9 byte load
        mk(32'h00100023, 0, 0, 0, 0, 0, 4, 9),                                  // R9 byte store
        mk(enc_s(12'hFFC, 1, 3), 0, 1, 32'hFFFFFFFE, 1, 32'd5, 4, 9),           // R9 x1 still 5
        mk(enc_i(12'hFFF, 1, 3'b010, 14, OL), 32'hA5A5A5A5, 1, 32'd4, 0, 0, 4, 4) // R4 lw neg
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] pc_before;
        rst_n        = 1'b0;
        instr_i      = 32'h0;
        dmem_rdata_i = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 pc after reset", pc_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag          = $sformatf("R%0d vec%0d", VECS[i].req, i);
            instr_i      = VECS[i].ins;
            dmem_rdata_i = VECS[i].rdat;
            #1;
            pc_before = pc_o;
            if (VECS[i].chka) check({tag, " addr"}, dmem_addr_o, VECS[i].addr);
            check({tag, " we"}, {31'h0, dmem_we_o}, {31'h0, VECS[i].we});
            if (VECS[i].we) check({tag, " wdata"}, dmem_wdata_o, VECS[i].wd);
            @(negedge clk);
            check({tag, " pc step"}, pc_o - pc_before, VECS[i].step);
        end

        // R4 result of the final load, read back through a store.
        instr_i = enc_s(12'd0, 14, 0);
        #1;
        check("R4 lw negative offset data", dmem_wdata_o, 32'hA5A5A5A5);

        // R1: reset is synchronous; PC holds until the edge, registers clear.
        instr_i = enc_i(12'd0, 0, 3'b000, 0, OI);
        @(negedge clk);
        pc_before = pc_o;
        rst_n = 1'b0;
        #1;
        check("R1 pc held before edge", pc_o, pc_before);
        @(negedge clk);
        check("R1 pc cleared", pc_o, 32'h0);
        rst_n   = 1'b1;
        instr_i = enc_s(12'd0, 1, 0);
        #1;
        check("R1 x1 cleared", dmem_wdata_o, 32'h0);
        instr_i = enc_s(12'd0, 5, 0);
        #1;
        check("R1 x5 cleared", dmem_wdata_o, 32'h0);
        @(negedge clk);
        check("R10 step after reset", pc_o, 32'd4);

        finish_run();
    end

endmodule